// File: doc/BRIEF.md
# Mailbox Virtual Register Access Engine

This block is the device side of a host mailbox belonging to an embedded controller. It occupies a ten-byte I/O window. A host assembles a one-entry request packet in a small mailbox buffer, selected through a 16-bit mailbox pointer. The packet holds an access type, an entry count and a data entry. The host also loads a 16-bit virtual register address and then starts the command by writing a trigger code to the host-to-controller register.

After a programmable number of clock cycles, the engine completes the command. A write command stores the data entry in an internal virtual register RAM. A read command copies the RAM byte back into the data entry of the mailbox. Completion is reported in two places: bit 0 of a write-one-to-clear interrupt source register, and a controller-to-host status byte. The status byte holds 0x01 on success and an error code when the packet is malformed.

Host reads have no side effects. The read data is a combinational function of the offset.

Top module: `mbx_vreg_engine`

## Requirements
- R1: After reset, offsets 0, 1, 2, 3 and 8 read 0x00.
- R2: Offsets 2 and 3 hold the low and high bytes of the mailbox pointer and read back as written. Offset 4 accesses mailbox byte (pointer mod MBX_BYTES). Offset 5 accesses the next byte, and that index also wraps modulo MBX_BYTES.
- R3: Offsets 6 and 7 hold the low and high bytes of the virtual register address and read back as written.
- R4: Writing 0x01 to offset 0 while idle starts a command. Offset 0 then reads 0x01 for exactly LATENCY cycles after the accepting clock edge and returns to 0x00 at completion.
- R5: Access type 0x03 (mailbox byte 0) with entry count 0x01 (mailbox byte 1) stores the data entry (mailbox byte 4) into RAM location (virtual address mod VREG_DEPTH).
- R6: Access type 0x02 with entry count 0x01 replaces mailbox byte 4 with the RAM byte at (virtual address mod VREG_DEPTH) at completion.
- R7: A valid command completes with offset 1 reading 0x01 and bit 0 of offset 8 set.
- R8: Any access type other than 0x02 or 0x03, or any entry count other than 0x01, completes with offset 1 reading ERR_CODE and bit 0 of offset 8 set. In this case the RAM and the mailbox are left unchanged.
- R9: Writing to offset 8 clears the interrupt bits written as 1 and leaves the others. Writing to offset 1 clears the status bits written as 1, so writing back the value read clears it.
- R10: A write to offset 0 while busy, or a write of any value other than 0x01, is ignored and does not change the completion time.
- R11: An accepted trigger clears the status byte to 0x00 for the duration of the command.
- R12: The access type, count, data entry and address are captured when the trigger is accepted. Host writes to them while busy do not affect the running command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| io_addr | input | 4 | Register offset within the window |
| io_wr | input | 1 | Write strobe, one write per cycle |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for io_addr, combinational |

## Verification
The bench builds the engine with LATENCY set to 6, VREG_DEPTH to 64, MBX_BYTES to 8 and ERR_CODE to 0x80. The short latency leaves room to issue retriggers and overwrite the packet while a command is in flight, yet still sample exactly one cycle before and at completion. The 64-entry RAM makes address aliasing reachable: addresses 0x0005 and 0x0045 hit the same location. The 8-byte mailbox makes the wrap of the offset-5 index reachable with the pointer at 7.

// File: rtl/mbx_vreg_pkg.sv
package mbx_vreg_pkg;

  // Register offsets inside the host window
  localparam int unsigned OFS_TRIG = 0;
  localparam int unsigned OFS_STAT = 1;
  localparam int unsigned OFS_PTRL = 2;
  localparam int unsigned OFS_PTRH = 3;
  localparam int unsigned OFS_DAT0 = 4;
  localparam int unsigned OFS_DAT1 = 5;
  localparam int unsigned OFS_VAL  = 6;
  localparam int unsigned OFS_VAH  = 7;
  localparam int unsigned OFS_ISRC = 8;

  // Codes
  localparam logic [7:0] ACC_RD = 8'h02;
  localparam logic [7:0] ACC_WR = 8'h03;
  localparam logic [7:0] CMD_GO = 8'h01;
  localparam logic [7:0] ST_OK  = 8'h01;
  localparam logic [7:0] CNT_ONE = 8'h01;

  // Mailbox byte positions of the packet
  localparam int unsigned HDR_TYPE_IDX = 0;
  localparam int unsigned HDR_CNT_IDX  = 1;
  localparam int unsigned ENTRY_IDX    = 4;

  typedef struct packed {
    logic [7:0] acc;
    logic [7:0] cnt;
    logic [7:0] data;
  } mbx_req_t;

endpackage

// File: rtl/mbx_window.sv
module mbx_window
  import mbx_vreg_pkg::*;
#(
  parameter int unsigned MBX_BYTES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we_ptrl,
  input  logic        we_ptrh,
  input  logic        we_d0,
  input  logic        we_d1,
  input  logic [7:0]  wdata,
  input  logic        eng_we,
  input  logic [7:0]  eng_wdata,
  output logic [15:0] ptr,
  output logic [7:0]  rd_d0,
  output logic [7:0]  rd_d1,
  output logic [7:0]  hdr_acc,
  output logic [7:0]  hdr_cnt,
  output logic [7:0]  entry
);

  localparam int unsigned IW = $clog2(MBX_BYTES);

  logic [15:0]   ptr_q, ptr_d;
  logic [7:0]    mb_q [MBX_BYTES];
  logic [7:0]    mb_d [MBX_BYTES];
  logic [IW-1:0] idx0, idx1;

  assign idx0 = ptr_q[IW-1:0];
  assign idx1 = idx0 + 1'b1;

  always_comb begin
    ptr_d = ptr_q;
    if (we_ptrl) ptr_d[7:0]  = wdata;
    if (we_ptrh) ptr_d[15:8] = wdata;
  end

  always_comb begin
    for (int i = 0; i < int'(MBX_BYTES); i++) mb_d[i] = mb_q[i];
    if (we_d0) mb_d[idx0] = wdata;
    if (we_d1) mb_d[idx1] = wdata;
    // engine result has priority over a host write in the same cycle
    if (eng_we) mb_d[ENTRY_IDX] = eng_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      for (int i = 0; i < int'(MBX_BYTES); i++) mb_q[i] <= '0;
    end else begin
      if (we_ptrl || we_ptrh) ptr_q <= ptr_d;
      if (we_d0 || we_d1 || eng_we) begin
        for (int i = 0; i < int'(MBX_BYTES); i++) mb_q[i] <= mb_d[i];
      end
    end
  end

  assign ptr     = ptr_q;
  assign rd_d0   = mb_q[idx0];
  assign rd_d1   = mb_q[idx1];
  assign hdr_acc = mb_q[HDR_TYPE_IDX];
  assign hdr_cnt = mb_q[HDR_CNT_IDX];
  assign entry   = mb_q[ENTRY_IDX];

endmodule

// File: rtl/mbx_vreg_ram.sv
module mbx_vreg_ram #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[addr] <= wdata;
  end

  assign rdata = mem_q[addr];

endmodule

// File: rtl/mbx_exec.sv
module mbx_exec
  import mbx_vreg_pkg::*;
#(
  parameter int unsigned LATENCY    = 20,
  parameter int unsigned VREG_DEPTH = 64,
  parameter logic [7:0]  ERR_CODE   = 8'h80,
  localparam int unsigned AW = $clog2(VREG_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  mbx_req_t      req,
  input  logic [AW-1:0] vidx,
  input  logic          stat_we,
  input  logic [7:0]    wdata,
  input  logic          isrc_clr,
  input  logic [7:0]    ram_rdata,
  output logic          busy,
  output logic          done,
  output logic [7:0]    status,
  output logic [7:0]    isrc,
  output logic [AW-1:0] ram_addr,
  output logic          ram_we,
  output logic [7:0]    ram_wdata,
  output logic          entry_we,
  output logic [7:0]    entry_wdata
);

  localparam int unsigned CW = (LATENCY > 1) ? $clog2(LATENCY) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(LATENCY - 1);

  mbx_req_t      req_q;
  logic [AW-1:0] vidx_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic [7:0]    status_q, status_d;
  logic          irq_q, irq_d;
  logic          accept, valid;

  assign accept = go && !busy_q;
  assign done   = busy_q && (cnt_q == '0);
  assign valid  = ((req_q.acc == ACC_RD) || (req_q.acc == ACC_WR)) &&
                  (req_q.cnt == CNT_ONE);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = CNT_LOAD;
    end else if (done) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_comb begin
    status_d = status_q;
    if (stat_we) status_d = status_q & ~wdata;
    if (accept)  status_d = 8'h00;
    if (done)    status_d = valid ? ST_OK : ERR_CODE;
    irq_d = irq_q;
    if (isrc_clr) irq_d = 1'b0;
    if (done)     irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      status_q <= '0;
      irq_q    <= 1'b0;
      req_q    <= '0;
      vidx_q   <= '0;
    end else begin
      busy_q   <= busy_d;
      cnt_q    <= cnt_d;
      status_q <= status_d;
      irq_q    <= irq_d;
      if (accept) begin
        req_q  <= req;
        vidx_q <= vidx;
      end
    end
  end

  assign busy        = busy_q;
  assign status      = status_q;
  assign isrc        = {7'b0, irq_q};
  assign ram_addr    = vidx_q;
  assign ram_we      = done && valid && (req_q.acc == ACC_WR);
  assign ram_wdata   = req_q.data;
  assign entry_we    = done && valid && (req_q.acc == ACC_RD);
  assign entry_wdata = ram_rdata;

endmodule

// File: rtl/mbx_vreg_engine.sv
module mbx_vreg_engine
  import mbx_vreg_pkg::*;
#(
  parameter int unsigned LATENCY    = 20,
  parameter int unsigned VREG_DEPTH = 64,
  parameter int unsigned MBX_BYTES  = 8,
  parameter logic [7:0]  ERR_CODE   = 8'h80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] io_addr,
  input  logic       io_wr,
  input  logic [7:0] io_wdata,
  output logic [7:0] io_rdata
);

  localparam int unsigned AW = $clog2(VREG_DEPTH);

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  // write decode
  logic hit_trig, hit_stat, hit_ptrl, hit_ptrh, hit_d0, hit_d1, hit_val, hit_vah, hit_isrc;
  assign hit_trig = io_wr && (io_addr == 4'(OFS_TRIG));
  assign hit_stat = io_wr && (io_addr == 4'(OFS_STAT));
  assign hit_ptrl = io_wr && (io_addr == 4'(OFS_PTRL));
  assign hit_ptrh = io_wr && (io_addr == 4'(OFS_PTRH));
  assign hit_d0   = io_wr && (io_addr == 4'(OFS_DAT0));
  assign hit_d1   = io_wr && (io_addr == 4'(OFS_DAT1));
  assign hit_val  = io_wr && (io_addr == 4'(OFS_VAL));
  assign hit_vah  = io_wr && (io_addr == 4'(OFS_VAH));
  assign hit_isrc = io_wr && (io_addr == 4'(OFS_ISRC));

  logic go;
  assign go = hit_trig && (io_wdata == CMD_GO);

  // virtual register address
  logic [15:0] vaddr_q, vaddr_d;

  always_comb begin
    vaddr_d = vaddr_q;
    if (hit_val) vaddr_d[7:0]  = io_wdata;
    if (hit_vah) vaddr_d[15:8] = io_wdata;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)          vaddr_q <= '0;
    else if (hit_val || hit_vah) vaddr_q <= vaddr_d;
  end

  // interconnect
  logic [15:0]   ptr;
  logic [7:0]    rd_d0, rd_d1, hdr_acc, hdr_cnt, entry;
  logic          busy, done;
  logic [7:0]    status, isrc;
  logic [AW-1:0] ram_addr;
  logic          ram_we, entry_we;
  logic [7:0]    ram_wdata, ram_rdata, entry_wdata;
  mbx_req_t      req;

  assign req = '{acc: hdr_acc, cnt: hdr_cnt, data: entry};

  mbx_window #(.MBX_BYTES(MBX_BYTES)) u_window (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .we_ptrl   (hit_ptrl),
    .we_ptrh   (hit_ptrh),
    .we_d0     (hit_d0),
    .we_d1     (hit_d1),
    .wdata     (io_wdata),
    .eng_we    (entry_we),
    .eng_wdata (entry_wdata),
    .ptr       (ptr),
    .rd_d0     (rd_d0),
    .rd_d1     (rd_d1),
    .hdr_acc   (hdr_acc),
    .hdr_cnt   (hdr_cnt),
    .entry     (entry)
  );

  mbx_exec #(
    .LATENCY   (LATENCY),
    .VREG_DEPTH(VREG_DEPTH),
    .ERR_CODE  (ERR_CODE)
  ) u_exec (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .go          (go),
    .req         (req),
    .vidx        (vaddr_q[AW-1:0]),
    .stat_we     (hit_stat),
    .wdata       (io_wdata),
    .isrc_clr    (hit_isrc && io_wdata[0]),
    .ram_rdata   (ram_rdata),
    .busy        (busy),
    .done        (done),
    .status      (status),
    .isrc        (isrc),
    .ram_addr    (ram_addr),
    .ram_we      (ram_we),
    .ram_wdata   (ram_wdata),
    .entry_we    (entry_we),
    .entry_wdata (entry_wdata)
  );

  mbx_vreg_ram #(.DEPTH(VREG_DEPTH)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (ram_rdata)
  );

  // side-effect-free read mux
  always_comb begin
    unique case (io_addr)
      4'(OFS_TRIG): io_rdata = {7'b0, busy};
      4'(OFS_STAT): io_rdata = status;
      4'(OFS_PTRL): io_rdata = ptr[7:0];
      4'(OFS_PTRH): io_rdata = ptr[15:8];
      4'(OFS_DAT0): io_rdata = rd_d0;
      4'(OFS_DAT1): io_rdata = rd_d1;
      4'(OFS_VAL):  io_rdata = vaddr_q[7:0];
      4'(OFS_VAH):  io_rdata = vaddr_q[15:8];
      4'(OFS_ISRC): io_rdata = isrc;
      default:      io_rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/mbx_vreg_engine_chk.sv
module mbx_vreg_engine_chk #(
  parameter int unsigned LATENCY = 20
) (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] io_addr,
  input logic       io_wr,
  input logic       wbit0,
  input logic       busy,
  input logic       done,
  input logic [7:0] status,
  input logic [7:0] isrc
);

  // cycles spent busy, counted independently of the engine counter
  logic [31:0] chk_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    chk_cnt <= '0;
    else if (busy) chk_cnt <= chk_cnt + 32'd1;
    else           chk_cnt <= '0;
  end

  assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (chk_cnt == 32'(LATENCY - 1)));

  assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  assert_done_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (isrc[0] && (status != 8'h00)));

  assert_isrc_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && io_wr && (io_addr == 4'd8) && wbit0) |=> !isrc[0]);

  assert_retrigger_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && io_wr && (io_addr == 4'd0)) |=> busy);

  assert_status_clear_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (status == 8'h00));

endmodule

bind mbx_vreg_engine mbx_vreg_engine_chk #(.LATENCY(LATENCY)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .io_addr (io_addr),
  .io_wr   (io_wr),
  .wbit0   (io_wdata[0]),
  .busy    (busy),
  .done    (done),
  .status  (status),
  .isrc    (isrc)
);

// File: tb/mbx_vreg_engine_test.sv
module mbx_vreg_engine_test;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 6;
  localparam int NVEC       = 9;

  // {acc, cnt, vaddr[15:0], data, exp_status, exp_entry}
  localparam logic [55:0] VEC [NVEC] = '{
    {8'h03, 8'h01, 16'h0005, 8'hA5, 8'h01, 8'hA5},  // R5 write
    {8'h02, 8'h01, 16'h0005, 8'h00, 8'h01, 8'hA5},  // R6 read
    {8'h03, 8'h01, 16'h0045, 8'h3C, 8'h01, 8'h3C},  // R5 aliased write
    {8'h02, 8'h01, 16'h0005, 8'h00, 8'h01, 8'h3C},  // R6 alias visible
    {8'h03, 8'h01, 16'h0012, 8'h7E, 8'h01, 8'h7E},
    {8'h05, 8'h01, 16'h0012, 8'hFF, 8'h80, 8'hFF},  // R8 bad type
    {8'h02, 8'h01, 16'h0012, 8'h00, 8'h01, 8'h7E},  // R8 RAM unchanged
    {8'h03, 8'h02, 16'h0012, 8'h11, 8'h80, 8'h11},  // R8 bad count
    {8'h02, 8'h01, 16'h0012, 8'h00, 8'h01, 8'h7E}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] io_addr;
  logic       io_wr;
  logic [7:0] io_wdata;
  logic [7:0] io_rdata;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbx_vreg_engine #(
    .LATENCY(LAT), .VREG_DEPTH(64), .MBX_BYTES(8), .ERR_CODE(8'h80)
  ) uut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata)
  );

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
    io_addr = a;
    #1;
    n_chk++;
    if (io_rdata !== exp) begin
      n_fail++;
      $display("FAIL %s: offset %0d actual %02h expected %02h", tag, a, io_rdata, exp);
    end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic clear_flags;
    io_addr = 4'd1; #1;
    wr(4'd1, io_rdata);
    wr(4'd8, 8'h01);
  endtask

  task automatic load_cmd(input logic [7:0] acc, input logic [7:0] cnt,
                          input logic [15:0] va, input logic [7:0] d);
    wr(4'd2, 8'h00); wr(4'd3, 8'h80);
    wr(4'd4, acc);   wr(4'd5, cnt);
    wr(4'd2, 8'h04); wr(4'd4, d);
    wr(4'd6, va[7:0]); wr(4'd7, va[15:8]);
  endtask

  task automatic run_cmd(input logic [7:0] acc, input logic [7:0] cnt,
                         input logic [15:0] va, input logic [7:0] d,
                         input logic [7:0] est, input logic [7:0] edat, input string tag);
    clear_flags();
    load_cmd(acc, cnt, va, d);
    wr(4'd0, 8'h01);
    repeat (LAT-1) @(negedge clk);
    chk({tag, " R4 busy before completion"}, 4'd0, 8'h01);
    chk({tag, " R7 no irq before completion"}, 4'd8, 8'h00);
    @(negedge clk);
    chk({tag, " R4 idle at completion"}, 4'd0, 8'h00);
    chk({tag, " R7/R8 status"}, 4'd1, est);
    chk({tag, " R7 irq bit"}, 4'd8, 8'h01);
    chk({tag, " R5/R6 entry"}, 4'd4, edat);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; io_wr = 1'b0; io_addr = '0; io_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 trigger", 4'd0, 8'h00);
    chk("R1 status",  4'd1, 8'h00);
    chk("R1 ptr lo",  4'd2, 8'h00);
    chk("R1 ptr hi",  4'd3, 8'h00);
    chk("R1 isrc",    4'd8, 8'h00);
    @(negedge clk);

    // R2 pointer and window wrap
    wr(4'd2, 8'h07); wr(4'd3, 8'h80);
    chk("R2 ptr lo readback", 4'd2, 8'h07);
    chk("R2 ptr hi readback", 4'd3, 8'h80);
    @(negedge clk);
    wr(4'd4, 8'hC1); wr(4'd5, 8'hD2);
    wr(4'd2, 8'h00);
    chk("R2 offset5 wrapped to byte 0", 4'd4, 8'hD2);
    @(negedge clk);
    wr(4'd2, 8'h06);
    chk("R2 offset5 at byte 7", 4'd5, 8'hC1);
    @(negedge clk);

    // R3 virtual address readback
    wr(4'd6, 8'h34); wr(4'd7, 8'h12);
    chk("R3 vaddr lo", 4'd6, 8'h34);
    chk("R3 vaddr hi", 4'd7, 8'h12);
    @(negedge clk);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      run_cmd(VEC[i][55:48], VEC[i][47:40], VEC[i][39:24], VEC[i][23:16],
              VEC[i][15:8], VEC[i][7:0], $sformatf("vec%0d", i));
      @(negedge clk);
    end

    // R9 write-one-to-clear behaviour (status 01, irq 1 from last vector)
    wr(4'd1, 8'h00);
    chk("R9 status kept on zero write", 4'd1, 8'h01);
    @(negedge clk);
    wr(4'd8, 8'h00);
    chk("R9 irq kept on zero write", 4'd8, 8'h01);
    @(negedge clk);
    wr(4'd8, 8'h01);
    chk("R9 irq cleared", 4'd8, 8'h00);
    @(negedge clk);
    wr(4'd1, 8'h01);
    chk("R9 status cleared by writing value back", 4'd1, 8'h00);
    @(negedge clk);

    // R10 trigger value other than 0x01 ignored
    wr(4'd0, 8'h02);
    chk("R10 wrong trigger not busy", 4'd0, 8'h00);
    @(negedge clk);
    repeat (LAT+2) @(negedge clk);
    chk("R10 wrong trigger no irq", 4'd8, 8'h00);
    chk("R10 wrong trigger no status", 4'd1, 8'h00);
    @(negedge clk);

    // R10 / R12 retrigger and packet edits while busy
    run_cmd(8'h03, 8'h01, 16'h0021, 8'h77, 8'h01, 8'h77, "prep21");
    @(negedge clk);
    clear_flags();
    load_cmd(8'h03, 8'h01, 16'h0020, 8'h5A);
    wr(4'd0, 8'h01);
    wr(4'd0, 8'h01);
    wr(4'd4, 8'hEE);
    wr(4'd6, 8'h21);
    wr(4'd0, 8'h01);
    repeat (LAT-1-4) @(negedge clk);
    chk("R10 still busy after retriggers", 4'd0, 8'h01);
    @(negedge clk);
    chk("R10 completion time unchanged", 4'd0, 8'h00);
    chk("R10 irq at original time", 4'd8, 8'h01);
    @(negedge clk);
    run_cmd(8'h02, 8'h01, 16'h0020, 8'h00, 8'h01, 8'h5A, "R12 captured data");
    @(negedge clk);
    run_cmd(8'h02, 8'h01, 16'h0021, 8'h00, 8'h01, 8'h77, "R12 other address untouched");
    @(negedge clk);

    // R11 accepted trigger clears status
    chk("R11 status before retrigger", 4'd1, 8'h01);
    @(negedge clk);
    wr(4'd0, 8'h01);
    chk("R11 status cleared while busy", 4'd1, 8'h00);
    chk("R11 busy", 4'd0, 8'h01);
    @(negedge clk);
    repeat (LAT) @(negedge clk);
    chk("R11 status after completion", 4'd1, 8'h01);

    summary();
  end

endmodule